// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Unit

This unit sits between the interrupt sources of a system and one processor. It keeps one pending interrupt slot and decides, by comparing priorities, whether an interrupt offered by a source is presented to the processor or handed back. A smaller priority number is more favoured. The processor sets its current priority and reads or acknowledges the pending interrupt through a 32-bit status word. The top byte of that word is the current processor priority. The low 24 bits are the pending source number, and a source number of zero means the slot is empty.

The unit also holds a software interrupt priority register. Writing it can present an inter-processor interrupt under the fixed source number `IPI_SRC`. When the processor lowers its urgency while the slot is empty, the unit asks the sources to send again whatever they had to withdraw. An acknowledge also names the finished source to the source side.

In each cycle the unit carries out at most one register operation. A source offer arriving in the same cycle is then judged against the state that this operation leaves.

Top module: `irq_presenter`

## Requirements
- R1: After reset the status word is 0, the software interrupt priority and the held pending priority are 0xFF, `irq_out` is low, and no pulse output is active.
- R2: When `rd_poll` is high, `rd_data` shows the status word (priority in bits 31:24, source in bits 23:0) and `rd_mfrr` shows the software interrupt priority, in the same cycle and with no change of state. When neither `rd_poll` nor `rd_accept` is high, `rd_data` is 0. When `rd_poll` is low, `rd_mfrr` is 0.
- R3: A valid offer is handed back if its priority is greater than or equal to the current priority, or if the slot holds an interrupt whose priority is less than or equal to the offered one. The handback is a one-cycle `off_rej_valid` pulse carrying the offered source number, in the cycle after the offer.
- R4: An offer that is not handed back takes the slot, and `irq_out` is high from the next cycle. If the slot held an interrupt from an external source, that source number is pulsed on `disp_valid`/`disp_src` in the next cycle.
- R5: A priority write whose value is below the old priority empties the slot if the slot is full and the new value is at most the pending priority. Emptying sets the pending priority to 0xFF, lowers `irq_out`, and pulses `disp_src` if the emptied interrupt came from an external source. If the pending priority is below the new value, the slot is kept.
- R6: A priority write whose value is not below the old priority, made while the slot is empty, pulses `resend_req`. If the software priority is then below the new priority, the software interrupt is presented.
- R7: A software priority write whose value is below the current priority presents the software interrupt (source `IPI_SRC`, pending priority equal to the written value). This does not happen if the slot already holds an interrupt with a priority at most the written value. An external interrupt pushed out this way is pulsed on `disp_src`.
- R8: During an accept, `rd_data` returns the status word in the same cycle. From the next cycle the current priority equals the old pending priority, the slot is empty, the pending priority is 0xFF, and `irq_out` is low.
- R9: An acknowledge write loads bits 31:24 into the current priority and pulses `eoi_valid` with bits 23:0 on `eoi_src` in the next cycle. If the slot is empty it also pulses `resend_req` and presents the software interrupt when its priority is below the new current priority. If the slot is full, no resend is issued.
- R10: A pending software interrupt never appears on `disp_src`, whether it is pushed out by an offer or cleared by a priority write.
- R11: When a register operation and an offer arrive in the same cycle, the operation is applied first and the offer is judged against the resulting state. A handback and a displacement may then both pulse in the same cycle.
- R12: If several operation strobes are high together, only the one with the highest precedence runs, in the order accept, acknowledge, priority write, software priority write. An offer with source number 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| offer_valid | input | 1 | Source offers an interrupt this cycle |
| offer_src | input | SRC_W | Offered source number |
| offer_prio | input | PRIO_W | Offered priority |
| wr_cppr | input | 1 | Write current priority from `wr_data[31:24]` |
| wr_mfrr | input | 1 | Write software interrupt priority from `wr_data[7:0]` |
| wr_eoi | input | 1 | Acknowledge write with `wr_data` |
| wr_data | input | STAT_W | Write data |
| rd_accept | input | 1 | Accept read: returns and clears the pending interrupt |
| rd_poll | input | 1 | Poll read with no side effect |
| rd_data | output | STAT_W | Status word during accept or poll |
| rd_mfrr | output | PRIO_W | Software interrupt priority during poll |
| irq_out | output | 1 | Interrupt line to the processor |
| off_rej_valid | output | 1 | Offered interrupt handed back |
| off_rej_src | output | SRC_W | Source number handed back |
| disp_valid | output | 1 | Pending external interrupt pushed out |
| disp_src | output | SRC_W | Source number pushed out |
| resend_req | output | 1 | Request to the sources to resend |
| eoi_valid | output | 1 | End-of-interrupt to a source |
| eoi_src | output | SRC_W | Source that finished |

## Verification
The read data `rd_data` and `rd_mfrr` are combinational: the bench checks them one time unit after driving the strobe, before the clock edge that applies the operation. Every other result is registered once. The status change, `irq_out` and the pulses `off_rej_valid`, `disp_valid`, `resend_req` and `eoi_valid` are due in the cycle after the stimulus edge. The driver pushes the expected item only after that edge, and the monitor pops and compares it at the following falling edge, so each item meets exactly the cycle it describes. State effects on the status word are checked through later poll reads.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

  // register operation selected for a cycle
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_CPPR   = 3'd1,
    OP_MFRR   = 3'd2,
    OP_EOI    = 3'd3,
    OP_ACCEPT = 3'd4
  } op_e;

  // fixed precedence: accept, acknowledge, priority, software priority
  function automatic op_e pick_op(input logic acc, input logic eoi,
                                  input logic cppr, input logic mfrr);
    if (acc)       return OP_ACCEPT;
    else if (eoi)  return OP_EOI;
    else if (cppr) return OP_CPPR;
    else if (mfrr) return OP_MFRR;
    else           return OP_NONE;
  endfunction

endpackage

// File: rtl/ipc_regop.sv
module ipc_regop
  import ipc_pkg::*;
#(
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned SRC_W   = 24,
  parameter int unsigned IPI_SRC = 2
) (
  input  op_e                      op,
  input  logic [PRIO_W+SRC_W-1:0]  wdata,
  input  logic [PRIO_W-1:0]        cur_cppr,
  input  logic [SRC_W-1:0]         cur_xisr,
  input  logic [PRIO_W-1:0]        cur_pend,
  input  logic                     cur_ext,
  input  logic [PRIO_W-1:0]        cur_mfrr,
  output logic [PRIO_W-1:0]        mid_cppr,
  output logic [SRC_W-1:0]         mid_xisr,
  output logic [PRIO_W-1:0]        mid_pend,
  output logic                     mid_ext,
  output logic [PRIO_W-1:0]        mid_mfrr,
  output logic                     disp_v,
  output logic [SRC_W-1:0]         disp_id,
  output logic                     resend,
  output logic                     eoi_v,
  output logic [SRC_W-1:0]         eoi_id
);
  localparam int unsigned STAT_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
  localparam logic [SRC_W-1:0]  IPI_ID = SRC_W'(IPI_SRC);

  // software interrupt stays out when the slot already beats it
  function automatic logic ipi_blocked(input logic [SRC_W-1:0] xisr,
                                       input logic [PRIO_W-1:0] pend,
                                       input logic [PRIO_W-1:0] mfrr);
    return (xisr != '0) && (pend <= mfrr);
  endfunction

  // lowering the priority drops a pending entry it no longer admits
  function automatic logic cppr_drops(input logic [SRC_W-1:0] xisr,
                                      input logic [PRIO_W-1:0] newp,
                                      input logic [PRIO_W-1:0] pend);
    return (xisr != '0) && (newp <= pend);
  endfunction

  logic [PRIO_W-1:0] wr_top;
  logic              ipi_try;

  assign wr_top = wdata[STAT_W-1 -: PRIO_W];

  always_comb begin
    mid_cppr = cur_cppr;
    mid_xisr = cur_xisr;
    mid_pend = cur_pend;
    mid_ext  = cur_ext;
    mid_mfrr = cur_mfrr;
    disp_v   = 1'b0;
    disp_id  = '0;
    resend   = 1'b0;
    eoi_v    = 1'b0;
    eoi_id   = '0;
    ipi_try  = 1'b0;

    unique case (op)
      OP_CPPR: begin
        mid_cppr = wr_top;
        if (wr_top < cur_cppr) begin
          if (cppr_drops(cur_xisr, wr_top, cur_pend)) begin
            mid_xisr = '0;
            mid_pend = PRIO_NONE;
            mid_ext  = 1'b0;
            if (cur_ext) begin
              disp_v  = 1'b1;
              disp_id = cur_xisr;
            end
          end
        end else if (cur_xisr == '0) begin
          resend  = 1'b1;
          ipi_try = (cur_mfrr < wr_top);
        end
      end
      OP_MFRR: begin
        mid_mfrr = wdata[PRIO_W-1:0];
        ipi_try  = (wdata[PRIO_W-1:0] < cur_cppr);
      end
      OP_EOI: begin
        mid_cppr = wr_top;
        eoi_v    = 1'b1;
        eoi_id   = wdata[SRC_W-1:0];
        if (cur_xisr == '0) begin
          resend  = 1'b1;
          ipi_try = (cur_mfrr < wr_top);
        end
      end
      OP_ACCEPT: begin
        mid_cppr = cur_pend;
        mid_xisr = '0;
        mid_pend = PRIO_NONE;
        mid_ext  = 1'b0;
      end
      default: ;
    endcase

    if (ipi_try && !ipi_blocked(mid_xisr, mid_pend, mid_mfrr)) begin
      if ((mid_xisr != '0) && mid_ext) begin
        disp_v  = 1'b1;
        disp_id = mid_xisr;
      end
      mid_xisr = IPI_ID;
      mid_pend = mid_mfrr;
      mid_ext  = 1'b0;
    end
  end

endmodule

// File: rtl/ipc_offer.sv
module ipc_offer #(
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned SRC_W  = 24
) (
  input  logic              offer_valid,
  input  logic [SRC_W-1:0]  offer_src,
  input  logic [PRIO_W-1:0] offer_prio,
  input  logic [PRIO_W-1:0] in_cppr,
  input  logic [SRC_W-1:0]  in_xisr,
  input  logic [PRIO_W-1:0] in_pend,
  input  logic              in_ext,
  output logic [SRC_W-1:0]  nxt_xisr,
  output logic [PRIO_W-1:0] nxt_pend,
  output logic              nxt_ext,
  output logic              rej_v,
  output logic [SRC_W-1:0]  rej_id,
  output logic              disp_v,
  output logic [SRC_W-1:0]  disp_id
);
  // an offer loses to the processor priority or to a no-worse pending entry
  function automatic logic offer_loses(input logic [PRIO_W-1:0] prio,
                                       input logic [PRIO_W-1:0] cppr,
                                       input logic [SRC_W-1:0]  xisr,
                                       input logic [PRIO_W-1:0] pend);
    return (prio >= cppr) || ((xisr != '0) && (pend <= prio));
  endfunction

  logic live;
  assign live = offer_valid && (offer_src != '0);

  always_comb begin
    nxt_xisr = in_xisr;
    nxt_pend = in_pend;
    nxt_ext  = in_ext;
    rej_v    = 1'b0;
    rej_id   = '0;
    disp_v   = 1'b0;
    disp_id  = '0;
    if (live) begin
      if (offer_loses(offer_prio, in_cppr, in_xisr, in_pend)) begin
        rej_v  = 1'b1;
        rej_id = offer_src;
      end else begin
        if ((in_xisr != '0) && in_ext) begin
          disp_v  = 1'b1;
          disp_id = in_xisr;
        end
        nxt_xisr = offer_src;
        nxt_pend = offer_prio;
        nxt_ext  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import ipc_pkg::*;
#(
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned SRC_W   = 24,
  parameter int unsigned IPI_SRC = 2,
  localparam int unsigned STAT_W = PRIO_W + SRC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              offer_valid,
  input  logic [SRC_W-1:0]  offer_src,
  input  logic [PRIO_W-1:0] offer_prio,
  input  logic              wr_cppr,
  input  logic              wr_mfrr,
  input  logic              wr_eoi,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              rd_accept,
  input  logic              rd_poll,
  output logic [STAT_W-1:0] rd_data,
  output logic [PRIO_W-1:0] rd_mfrr,
  output logic              irq_out,
  output logic              off_rej_valid,
  output logic [SRC_W-1:0]  off_rej_src,
  output logic              disp_valid,
  output logic [SRC_W-1:0]  disp_src,
  output logic              resend_req,
  output logic              eoi_valid,
  output logic [SRC_W-1:0]  eoi_src
);
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  logic [PRIO_W-1:0] cppr_q, pend_q, mfrr_q;
  logic [SRC_W-1:0]  xisr_q;
  logic              ext_q;

  op_e               op_sel;
  logic [PRIO_W-1:0] mid_cppr, mid_pend, mid_mfrr, nxt_pend;
  logic [SRC_W-1:0]  mid_xisr, nxt_xisr;
  logic              mid_ext, nxt_ext;
  logic              rop_disp, rop_resend, rop_eoi;
  logic [SRC_W-1:0]  rop_disp_id, rop_eoi_id;
  logic              off_rej, off_disp;
  logic [SRC_W-1:0]  off_rej_id, off_disp_id;

  assign op_sel = pick_op(rd_accept, wr_eoi, wr_cppr, wr_mfrr);

  ipc_regop #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_regop (
    .op(op_sel), .wdata(wr_data),
    .cur_cppr(cppr_q), .cur_xisr(xisr_q), .cur_pend(pend_q),
    .cur_ext(ext_q), .cur_mfrr(mfrr_q),
    .mid_cppr(mid_cppr), .mid_xisr(mid_xisr), .mid_pend(mid_pend),
    .mid_ext(mid_ext), .mid_mfrr(mid_mfrr),
    .disp_v(rop_disp), .disp_id(rop_disp_id),
    .resend(rop_resend), .eoi_v(rop_eoi), .eoi_id(rop_eoi_id)
  );

  ipc_offer #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_offer (
    .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
    .in_cppr(mid_cppr), .in_xisr(mid_xisr), .in_pend(mid_pend), .in_ext(mid_ext),
    .nxt_xisr(nxt_xisr), .nxt_pend(nxt_pend), .nxt_ext(nxt_ext),
    .rej_v(off_rej), .rej_id(off_rej_id),
    .disp_v(off_disp), .disp_id(off_disp_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cppr_q        <= '0;
      xisr_q        <= '0;
      pend_q        <= PRIO_NONE;
      ext_q         <= 1'b0;
      mfrr_q        <= PRIO_NONE;
      off_rej_valid <= 1'b0;
      off_rej_src   <= '0;
      disp_valid    <= 1'b0;
      disp_src      <= '0;
      resend_req    <= 1'b0;
      eoi_valid     <= 1'b0;
      eoi_src       <= '0;
    end else begin
      cppr_q        <= mid_cppr;
      xisr_q        <= nxt_xisr;
      pend_q        <= nxt_pend;
      ext_q         <= nxt_ext;
      mfrr_q        <= mid_mfrr;
      off_rej_valid <= off_rej;
      off_rej_src   <= off_rej_id;
      disp_valid    <= rop_disp | off_disp;
      disp_src      <= rop_disp ? rop_disp_id : off_disp_id;
      resend_req    <= rop_resend;
      eoi_valid     <= rop_eoi;
      eoi_src       <= rop_eoi_id;
    end
  end

  assign irq_out = (xisr_q != '0);
  assign rd_data = (rd_accept || rd_poll) ? {cppr_q, xisr_q} : '0;
  assign rd_mfrr = rd_poll ? mfrr_q : '0;

  // R3
  offer_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_rej_valid |-> $past(offer_valid));

  // R10
  disp_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> $past(ext_q));

  // R4
  single_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rop_disp, off_disp}));

  // R8
  accept_cppr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> (cppr_q == $past(pend_q)));

  // R8
  empty_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xisr_q == '0) |-> (pend_q == PRIO_NONE));

  // R6
  resend_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resend_req |-> ($past(xisr_q) == '0));

  // R2
  poll_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_poll && !rd_accept && !wr_cppr && !wr_mfrr && !wr_eoi && !offer_valid)
    |=> ($stable(cppr_q) && $stable(xisr_q) && $stable(mfrr_q)));

endmodule

// File: tb/irq_presenter_test.sv
module irq_presenter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        offer_valid = 1'b0;
  logic [23:0] offer_src = '0;
  logic [7:0]  offer_prio = '0;
  logic        wr_cppr = 1'b0, wr_mfrr = 1'b0, wr_eoi = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_accept = 1'b0, rd_poll = 1'b0;
  logic [31:0] rd_data;
  logic [7:0]  rd_mfrr;
  logic        irq_out, off_rej_valid, disp_valid, resend_req, eoi_valid;
  logic [23:0] off_rej_src, disp_src, eoi_src;

  always #5 clk = ~clk;

  irq_presenter uut (
    .clk(clk), .rst_n(rst_n), .offer_valid(offer_valid), .offer_src(offer_src),
    .offer_prio(offer_prio), .wr_cppr(wr_cppr), .wr_mfrr(wr_mfrr), .wr_eoi(wr_eoi),
    .wr_data(wr_data), .rd_accept(rd_accept), .rd_poll(rd_poll), .rd_data(rd_data),
    .rd_mfrr(rd_mfrr), .irq_out(irq_out), .off_rej_valid(off_rej_valid),
    .off_rej_src(off_rej_src), .disp_valid(disp_valid), .disp_src(disp_src),
    .resend_req(resend_req), .eoi_valid(eoi_valid), .eoi_src(eoi_src)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit          irq;
    bit          rv;
    logic [23:0] rs;
    bit          dv;
    logic [23:0] ds;
    bit          rsd;
    bit          ev;
    logic [23:0] es;
    string       tag;
  } exp_t;

  exp_t sb[$];

  // bench model of the requirements
  logic [7:0]  m_cppr = 8'h00;
  logic [23:0] m_xisr = '0;
  logic [7:0]  m_pend = 8'hFF;
  bit          m_ext  = 1'b0;
  logic [7:0]  m_mfrr = 8'hFF;

  task automatic try_ipi(inout exp_t e);
    if (m_xisr != 0 && m_pend <= m_mfrr) return;
    if (m_xisr != 0 && m_ext) begin e.dv = 1; e.ds = m_xisr; end
    m_xisr = 24'd2; m_pend = m_mfrr; m_ext = 0;
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic op(input bit acc, input bit eoi, input bit cp, input bit mf,
                    input bit poll, input logic [31:0] d, input bit ov,
                    input logic [23:0] os, input logic [7:0] opr, input string tag);
    exp_t e;
    logic [7:0] nc;
    e.irq = 0; e.rv = 0; e.rs = 0; e.dv = 0; e.ds = 0;
    e.rsd = 0; e.ev = 0; e.es = 0; e.tag = tag;
    @(negedge clk);
    rd_accept = acc; wr_eoi = eoi; wr_cppr = cp; wr_mfrr = mf; rd_poll = poll;
    wr_data = d; offer_valid = ov; offer_src = os; offer_prio = opr;
    #1;
    if (acc || poll)
      check(rd_data == {m_cppr, m_xisr}, {tag, " read word (R2/R8)"}, rd_data, {m_cppr, m_xisr});
    else
      check(rd_data == 0, "R2 idle read", rd_data, 0);
    if (poll) check(rd_mfrr == m_mfrr, "R2 poll mfrr", {24'h0, rd_mfrr}, {24'h0, m_mfrr});
    // register operation first (R11), precedence per R12
    if (acc) begin
      m_cppr = m_pend; m_xisr = 0; m_pend = 8'hFF; m_ext = 0;
    end else if (eoi) begin
      m_cppr = d[31:24]; e.ev = 1; e.es = d[23:0];
      if (m_xisr == 0) begin e.rsd = 1; if (m_mfrr < m_cppr) try_ipi(e); end
    end else if (cp) begin
      nc = d[31:24];
      if (nc < m_cppr) begin
        if (m_xisr != 0 && nc <= m_pend) begin
          if (m_ext) begin e.dv = 1; e.ds = m_xisr; end
          m_xisr = 0; m_pend = 8'hFF; m_ext = 0;
        end
        m_cppr = nc;
      end else begin
        m_cppr = nc;
        if (m_xisr == 0) begin e.rsd = 1; if (m_mfrr < m_cppr) try_ipi(e); end
      end
    end else if (mf) begin
      m_mfrr = d[7:0];
      if (m_mfrr < m_cppr) try_ipi(e);
    end
    if (ov && os != 0) begin
      if (opr >= m_cppr || (m_xisr != 0 && m_pend <= opr)) begin
        e.rv = 1; e.rs = os;
      end else begin
        if (m_xisr != 0 && m_ext) begin e.dv = 1; e.ds = m_xisr; end
        m_xisr = os; m_pend = opr; m_ext = 1;
      end
    end
    e.irq = (m_xisr != 0);
    @(posedge clk);
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic poll(input string tag);
    op(0, 0, 0, 0, 1, 0, 0, 0, 0, tag);
  endtask
  task automatic offer(input logic [23:0] s, input logic [7:0] p, input string tag);
    op(0, 0, 0, 0, 0, 0, 1, s, p, tag);
  endtask
  task automatic set_cppr(input logic [7:0] p, input string tag);
    op(0, 0, 1, 0, 0, {p, 24'h0}, 0, 0, 0, tag);
  endtask
  task automatic set_mfrr(input logic [7:0] p, input string tag);
    op(0, 0, 0, 1, 0, {24'h0, p}, 0, 0, 0, tag);
  endtask

  // monitor: compare registered results one cycle after each stimulus
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        bit ok;
        e = sb.pop_front();
        ok = (irq_out == e.irq) && (off_rej_valid == e.rv) && (disp_valid == e.dv)
          && (resend_req == e.rsd) && (eoi_valid == e.ev)
          && (!e.rv || off_rej_src == e.rs) && (!e.dv || disp_src == e.ds)
          && (!e.ev || eoi_src == e.es);
        check(ok, e.tag,
          {3'b0, irq_out, 3'b0, off_rej_valid, 3'b0, disp_valid, 3'b0, resend_req,
           3'b0, eoi_valid, disp_src[11:0]},
          {3'b0, e.irq, 3'b0, e.rv, 3'b0, e.dv, 3'b0, e.rsd, 3'b0, e.ev, e.ds[11:0]});
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    check(irq_out == 0 && !off_rej_valid && !disp_valid && !resend_req && !eoi_valid,
          "R1 reset outputs", {31'h0, irq_out}, 0);
    poll("R1 reset state");
    offer(24'h000005, 8'h05, "R3 reject vs priority zero");
    set_cppr(8'hFF, "R6 raise with empty slot");
    offer(24'h000100, 8'h10, "R4 accept into empty slot");
    offer(24'h000200, 8'h20, "R3 reject worse than pending");
    offer(24'h000300, 8'h10, "R3 reject equal to pending");
    offer(24'h000400, 8'h08, "R4 preempt external");
    poll("R2 poll status");
    op(1, 0, 0, 0, 0, 0, 0, 0, 0, "R8 accept");
    poll("R8 after accept");
    op(0, 1, 0, 0, 0, 32'hFF000400, 0, 0, 0, "R9 eoi with empty slot");
    set_mfrr(8'h30, "R7 ipi presented");
    offer(24'h000500, 8'h40, "R3 reject vs ipi");
    offer(24'h000500, 8'h20, "R10 offer over ipi");
    set_mfrr(8'h28, "R7 ipi blocked");
    set_mfrr(8'h10, "R7 ipi displaces external");
    set_cppr(8'h05, "R5 R10 clear ipi");
    set_cppr(8'h60, "R6 resend with ipi");
    op(1, 0, 0, 0, 0, 0, 0, 0, 0, "R8 accept ipi");
    set_cppr(8'hFF, "R6 resend ipi again");
    set_mfrr(8'hFF, "R7 no ipi");
    op(1, 0, 0, 0, 0, 0, 0, 0, 0, "R8 accept");
    set_cppr(8'hFF, "R6 resend plain");
    offer(24'h000600, 8'h50, "R4 accept");
    set_cppr(8'h40, "R5 clear external");
    set_cppr(8'hFF, "R6 resend");
    offer(24'h000700, 8'h50, "R4 accept");
    set_cppr(8'h60, "R5 keep better pending");
    poll("R5 status kept");
    op(0, 0, 1, 0, 0, 32'h20000000, 1, 24'h000800, 8'h30, "R11 write then offer");
    poll("R11 status");
    offer(24'h000000, 8'h00, "R12 source zero ignored");
    poll("R12 state after zero offer");
    set_cppr(8'hFF, "R6 resend");
    offer(24'h000900, 8'h10, "R4 accept");
    op(1, 0, 1, 0, 0, 32'h00000000, 0, 0, 0, "R12 accept beats cppr");
    poll("R12 precedence result");
    offer(24'h000A00, 8'h05, "R4 accept");
    op(0, 1, 0, 0, 0, 32'h10000123, 0, 0, 0, "R9 eoi with full slot");
    poll("R9 status");
    idle("idle");
    idle("idle");
    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule